// File: doc/BRIEF.md
# I2C Slave Clock Stretch Controller

This block decides when an I2C slave holds SCL low so that the host-side software can keep up with the bus. It owns the readable release flag. When the flag is 0 and the slave is addressed, the block drives a registered pull-low request toward the SCL pad. The flag returns to 1 on a software release write, on a STOP, or when the slave is no longer addressed.

Stretching is forced in transmit mode. After the falling edge of the ninth clock, if the transmit buffer is empty, the flag is cleared so that the bus waits until the next byte is loaded. In receive mode, a stretch follows each completed byte only when the stretch-enable bit is set. The same bit decides whether software may clear the flag itself to stretch on demand. Address matching, data shifting and the open-drain pad sit outside this block.

Top module: `i2c_stretch_ctl`

## Requirements
- R1: After reset, `rel_bit` is 1 and `scl_hold` is 0.
- R2: While addressed with `is_tx`=1, a cycle carrying `scl_fall`=1, `ninth_bit`=1 and `txbuf_full`=0 makes `rel_bit` 0 and `scl_hold` 1 on the next clock. This happens whatever the value of `stretch_en`.
- R3: In transmit mode, a ninth-clock falling edge with `txbuf_full`=1 has no effect on `rel_bit` or `scl_hold`. A falling edge with `ninth_bit`=0 also has no effect.
- R4: While addressed with `is_tx`=0, a `rx_done` pulse makes `rel_bit` 0 and `scl_hold` 1 on the next clock if `stretch_en`=1. If `stretch_en`=0, the pulse leaves both outputs unchanged.
- R5: A software write (`sw_wr`=1) with `sw_val`=1 makes `rel_bit` 1 and `scl_hold` 0 on the next clock.
- R6: A software write with `sw_val`=0 while `stretch_en`=0 is ignored, and `rel_bit` keeps its value.
- R7: A software write with `sw_val`=0 while `stretch_en`=1 and addressed makes `rel_bit` 0 and `scl_hold` 1 on the next clock.
- R8: A `stop_seen` pulse, or `addressed`=0, makes `rel_bit` 1 and `scl_hold` 0 on the next clock.
- R9: When a stretch trigger (R2 or R4) and a software release write fall in the same cycle, the stretch wins and `rel_bit` is 0 on the next clock.
- R10: `scl_hold` is a register output. It is 1 only while `rel_bit` is 0, and it is never 1 in the cycle after `addressed` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addressed | input | 1 | Slave currently selected by the master |
| stop_seen | input | 1 | One-cycle pulse on a bus STOP |
| scl_fall | input | 1 | One-cycle pulse on an SCL falling edge |
| ninth_bit | input | 1 | Bit counter is at the acknowledge (ninth) clock |
| is_tx | input | 1 | 1 = slave transmits, 0 = slave receives |
| txbuf_full | input | 1 | Transmit buffer holds a byte |
| rx_done | input | 1 | One-cycle pulse when a received byte is complete |
| stretch_en | input | 1 | Enables receive stretching and software clears |
| sw_wr | input | 1 | Software write strobe for the release flag |
| sw_val | input | 1 | Value software writes to the release flag |
| scl_hold | output | 1 | Registered request to pull SCL low |
| rel_bit | output | 1 | Readable release flag |

## Verification
A hardware stretch trigger and a software release write can land in the same cycle. This happens when the ninth-clock edge arrives with an empty buffer, or when a byte completes, while software is writing 1 to release the previous stretch. The bench provokes this directly and then repeatedly through random strobes. It expects the flag to read 0 and the hold request to be asserted on the next clock. A STOP or loss of address in that same cycle must override both.

// File: rtl/i2c_stretch_ctl.sv
module i2c_stretch_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic addressed,
  input  logic stop_seen,
  input  logic scl_fall,
  input  logic ninth_bit,
  input  logic is_tx,
  input  logic txbuf_full,
  input  logic rx_done,
  input  logic stretch_en,
  input  logic sw_wr,
  input  logic sw_val,
  output logic scl_hold,
  output logic rel_bit
);

  logic rel_q, rel_d, hold_q;

  wire tx_trig  = addressed & is_tx & scl_fall & ninth_bit & ~txbuf_full;
  wire rx_trig  = addressed & ~is_tx & rx_done & stretch_en;
  wire sw_set   = sw_wr & sw_val;
  wire sw_clr   = sw_wr & ~sw_val & stretch_en;
  wire drop_bus = ~addressed | stop_seen;

  always_comb begin
    rel_d = rel_q;
    if (drop_bus)                rel_d = 1'b1;
    else if (tx_trig || rx_trig) rel_d = 1'b0;
    else if (sw_set)             rel_d = 1'b1;
    else if (sw_clr)             rel_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_q  <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      rel_q  <= rel_d;
      hold_q <= addressed & ~rel_d;
    end
  end

  assign rel_bit  = rel_q;
  assign scl_hold = hold_q;

endmodule

// File: rtl/i2c_stretch_ctl_chk.sv
module i2c_stretch_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic addressed,
  input logic stop_seen,
  input logic scl_fall,
  input logic ninth_bit,
  input logic is_tx,
  input logic txbuf_full,
  input logic rx_done,
  input logic stretch_en,
  input logic sw_wr,
  input logic sw_val,
  input logic scl_hold,
  input logic rel_bit
);

  wire live = addressed & ~stop_seen;
  wire trig = live & ((is_tx & scl_fall & ninth_bit & ~txbuf_full) |
                      (~is_tx & rx_done & stretch_en));
  wire quiet_rx = ~(~is_tx & rx_done & stretch_en);
  wire quiet_tx = ~(is_tx & scl_fall & ninth_bit & ~txbuf_full);

  assert_tx_stretch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && is_tx && scl_fall && ninth_bit && !txbuf_full) |=> (!rel_bit && scl_hold));

  assert_rx_stretch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !is_tx && rx_done && stretch_en) |=> (!rel_bit && scl_hold));

  assert_sw_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && sw_wr && sw_val && quiet_rx && quiet_tx) |=> (rel_bit && !scl_hold));

  assert_clr_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && sw_wr && !sw_val && !stretch_en && quiet_tx) |=> $stable(rel_bit));

  assert_drop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!addressed || stop_seen) |=> (rel_bit && !scl_hold));

  assert_race_stretch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && sw_wr && sw_val) |=> !rel_bit);

  assert_hold_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> !rel_bit);

endmodule

bind i2c_stretch_ctl i2c_stretch_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addressed(addressed), .stop_seen(stop_seen),
  .scl_fall(scl_fall), .ninth_bit(ninth_bit), .is_tx(is_tx),
  .txbuf_full(txbuf_full), .rx_done(rx_done), .stretch_en(stretch_en),
  .sw_wr(sw_wr), .sw_val(sw_val), .scl_hold(scl_hold), .rel_bit(rel_bit)
);

// File: tb/tb_i2c_stretch_ctl.sv
module tb_i2c_stretch_ctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addressed = 0, stop_seen = 0, scl_fall = 0, ninth_bit = 0, is_tx = 0;
  logic txbuf_full = 0, rx_done = 0, stretch_en = 0, sw_wr = 0, sw_val = 0;
  logic scl_hold, rel_bit;
  logic m_rel = 1'b1, m_hold = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stretch_ctl dut (
    .clk(clk), .rst_n(rst_n), .addressed(addressed), .stop_seen(stop_seen),
    .scl_fall(scl_fall), .ninth_bit(ninth_bit), .is_tx(is_tx),
    .txbuf_full(txbuf_full), .rx_done(rx_done), .stretch_en(stretch_en),
    .sw_wr(sw_wr), .sw_val(sw_val), .scl_hold(scl_hold), .rel_bit(rel_bit)
  );

  function automatic logic want_rel(input logic r);
    if (!addressed || stop_seen) return 1'b1;
    if (is_tx && scl_fall && ninth_bit && !txbuf_full) return 1'b0;
    if (!is_tx && rx_done && stretch_en) return 1'b0;
    if (sw_wr && sw_val) return 1'b1;
    if (sw_wr && !sw_val && stretch_en) return 1'b0;
    return r;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (rel_bit !== m_rel || scl_hold !== m_hold) begin
      errors++;
      $display("FAIL %s: rel=%b hold=%b expected rel=%b hold=%b",
               tag, rel_bit, scl_hold, m_rel, m_hold);
    end
  endtask

  task automatic clear_strobes();
    stop_seen = 0; scl_fall = 0; ninth_bit = 0; rx_done = 0; sw_wr = 0; sw_val = 0;
  endtask

  // inputs are set at negedge; model advances across the posedge; compare at next negedge
  task automatic cyc(input string tag);
    logic nr;
    @(posedge clk);
    nr = want_rel(m_rel);
    m_hold = addressed & ~nr;
    m_rel = nr;
    @(negedge clk);
    check(tag);
    clear_strobes();
  endtask

  initial begin
    #(CLK_PERIOD * 3000);
    errors++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    addressed = 1; is_tx = 1; stretch_en = 0;
    cyc("R1");
    scl_fall = 1; ninth_bit = 1; txbuf_full = 0; cyc("R2");
    sw_wr = 1; sw_val = 1; cyc("R5");
    stretch_en = 1; scl_fall = 1; ninth_bit = 1; cyc("R2");
    sw_wr = 1; sw_val = 1; cyc("R5");
    txbuf_full = 1; scl_fall = 1; ninth_bit = 1; cyc("R3");
    txbuf_full = 0; scl_fall = 1; ninth_bit = 0; cyc("R3");
    is_tx = 0; stretch_en = 0; rx_done = 1; cyc("R4");
    stretch_en = 1; rx_done = 1; cyc("R4");
    sw_wr = 1; sw_val = 1; cyc("R5");
    stretch_en = 0; sw_wr = 1; sw_val = 0; cyc("R6");
    stretch_en = 1; sw_wr = 1; sw_val = 0; cyc("R7");
    stretch_en = 0; sw_wr = 1; sw_val = 1; cyc("R5");
    stretch_en = 1; rx_done = 1; cyc("R4");
    stretch_en = 0; sw_wr = 1; sw_val = 0; cyc("R6");
    stop_seen = 1; cyc("R8");
    stretch_en = 1; sw_wr = 1; sw_val = 0; cyc("R7");
    addressed = 0; cyc("R8");
    addressed = 1; cyc("R8");
    is_tx = 1; scl_fall = 1; ninth_bit = 1; sw_wr = 1; sw_val = 1; cyc("R9");
    is_tx = 0; rx_done = 1; sw_wr = 1; sw_val = 1; cyc("R9");
    is_tx = 1; scl_fall = 1; ninth_bit = 1; stop_seen = 1; cyc("R8");

    void'($urandom(32'h5eed));
    for (int i = 0; i < 600; i++) begin
      addressed  = ($urandom % 10) != 0;
      stop_seen  = ($urandom % 16) == 0;
      is_tx      = $urandom % 2;
      scl_fall   = $urandom % 2;
      ninth_bit  = ($urandom % 3) == 0;
      txbuf_full = $urandom % 2;
      rx_done    = ($urandom % 4) == 0;
      stretch_en = $urandom % 2;
      sw_wr      = ($urandom % 3) == 0;
      sw_val     = $urandom % 2;
      cyc(stop_seen || !addressed ? "R8" : (sw_wr ? "R9" : "R10"));
      if (scl_hold && rel_bit) begin
        errors++;
        $display("FAIL R10: hold=1 with rel=1, expected rel=0");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule